// File: doc/BRIEF.md
# Memory Controller Local Request Front End

This block sits between user logic and the scheduling core of a DRAM controller. User logic issues burst reads and burst writes through a word-addressed request port with a request/ready handshake. It can also ask for refreshes of selected chip selects. The block turns each accepted burst into exactly one command in a small command queue, and each selected chip of a refresh request into one refresh command. The queue drains through a valid/ready stream into the rest of the controller.

For a write burst, the block samples the beat count, address and autoprecharge hint on the first data beat. It counts the remaining beats and forwards every beat on a registered write-data output. The write command is queued only once the final beat has been taken. A read is a single request cycle and is queued at once. Illegal use of the port does not enqueue anything and sets a sticky error flag. Two kinds of illegal use are checked: overlapping read and write requests, and a zero beat count.

Top module: `memReqFrontEnd`

## Requirements
- R1: A read taken on `reqRead && reqReady` with a `reqSize` from 1 to MAX_BURST queues one command with kind 0 (read), the request's address and its beat count.
- R2: `reqSize` is sampled only on the first beat of a write burst, and the size on later beats has no effect. The write command (kind 1) is queued with the first beat's address and size after the last beat has been accepted.
- R3: If `reqRead` and `reqWrite` are high in the same cycle, or `reqRead` is high while a write burst is open, neither request is taken and `errProto` goes high and stays high.
- R4: While `rstN` is low, and in the first cycle after it rises, `reqReady` is low and no request is taken. After reset `cmdValid`, `errProto` and `errSize` are low.
- R5: Each accepted write beat appears one cycle later on `wdOutData` with `wdOutValid` high, and `wdOutLast` is high on the final beat. The data width is MEM_DQ_W times RATE_MULT, where RATE_MULT is 2, 4 or 8.
- R6: `reqAutoPch`, sampled with a read or with the first write beat, is carried to `cmdAutoPch` of that burst's command.
- R7: A refresh request with mask `refChipMask` (bit i selects chip i, active high) queues one refresh command (kind 2) for each set bit, in ascending chip order, with the chip number on `cmdChip`. Mask 0101 yields chips 0 then 2.
- R8: `reqReady` is low while the queue holds QUEUE_DEPTH commands, and while a refresh fan-out is still emitting commands. A refresh is taken only when `reqReady` is high, no read or write request is present and no write burst is open.
- R9: A read or first write beat with `reqSize` of 0 is consumed and dropped. No command is queued, no data beat is forwarded, and `errSize` goes high and stays high.
- R10: A refresh request with an all-zero mask queues nothing, and `reqReady` stays high in the following cycle.
- R11: The queue delivers commands in order. A command leaves when `cmdValid && cmdReady` are both high, and the output fields hold while the command is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqRead | input | 1 | Read request |
| reqWrite | input | 1 | Write beat request |
| reqAddr | input | ADDR_W | Burst start address |
| reqSize | input | SIZE_W | Burst beat count, binary |
| reqWdata | input | MEM_DQ_W*RATE_MULT | Write beat data |
| reqAutoPch | input | 1 | Autoprecharge hint for this burst |
| refReq | input | 1 | User refresh request |
| refChipMask | input | NUM_CS | Chips to refresh, one bit per chip |
| reqReady | output | 1 | Request port can take a transfer |
| cmdValid | output | 1 | Queue head is valid |
| cmdReady | input | 1 | Downstream takes the queue head |
| cmdKind | output | 2 | 0 read, 1 write, 2 refresh |
| cmdAddr | output | ADDR_W | Command address (0 for refresh) |
| cmdSize | output | SIZE_W | Command beat count (0 for refresh) |
| cmdAutoPch | output | 1 | Autoprecharge tag |
| cmdChip | output | CS_W | Refresh target chip (0 otherwise) |
| wdOutValid | output | 1 | Forwarded write beat valid |
| wdOutData | output | MEM_DQ_W*RATE_MULT | Forwarded write beat data |
| wdOutLast | output | 1 | Forwarded beat ends its burst |
| errProto | output | 1 | Sticky read/write overlap error |
| errSize | output | 1 | Sticky zero-size error |

## Verification
Several properties are checked on every cycle:
- nothing is pushed into a full queue;
- a stalled queue head keeps its fields;
- back-to-back refresh pushes name strictly rising chips;
- a fan-out with a non-zero mask pulls `reqReady` low in the next cycle;
- both error flags stay set.

Other behaviours can be shown only by the bench's scenarios. These are the beat counting across idle gaps and the size being ignored on later beats, the payload of each command, the fan-out order and the dropping of illegal requests. The bench compares every dequeued command and every forwarded beat with a model driven by the same stimulus.

// File: rtl/memfe_pkg.sv
package memfe_pkg;

  typedef enum logic [1:0] {
    KIND_READ    = 2'd0,
    KIND_WRITE   = 2'd1,
    KIND_REFRESH = 2'd2
  } cmdKind_e;

  // Strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic pushRw;       // enqueue a read or write command
    logic isWrite;      // the pushed command is a write
    logic useCaptured;  // take addr/size/autopch from the first-beat capture
    logic capture;      // latch first-beat fields of a multi-beat write
    logic pushRefresh;  // enqueue one refresh command
    logic wdBeat;       // forward the current write beat
    logic wdLast;       // the forwarded beat is the last one
  } ctlStrobe_t;

endpackage

// File: rtl/memfe_ctrl.sv
module memfe_ctrl
  import memfe_pkg::*;
#(
  parameter int SIZE_W = 5,
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqRead,
  input  logic              reqWrite,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              refReq,
  input  logic [NUM_CS-1:0] refChipMask,
  input  logic              queueFull,
  output logic              reqReady,
  output ctlStrobe_t        strobe,
  output logic [CS_W-1:0]   refChip,
  output logic              errProto,
  output logic              errSize
);

  logic              live;
  logic              burstOpen;
  logic [SIZE_W-1:0] remain;
  logic [NUM_CS-1:0] fanMask;
  logic              fanBusy, accept, rdGo, wrGo, refGo, sizeZero, conflict;

  assign fanBusy  = |fanMask;
  assign accept   = live && !queueFull && !fanBusy;
  assign sizeZero = (reqSize == '0);
  assign conflict = (reqRead && reqWrite) || (burstOpen && reqRead);
  assign rdGo     = accept && reqRead && !reqWrite && !burstOpen;
  assign wrGo     = accept && reqWrite && !reqRead;
  assign refGo    = accept && refReq && !reqRead && !reqWrite && !burstOpen;
  assign reqReady = accept;

  // lowest pending chip of the fan-out
  always_comb begin
    logic found;
    found   = 1'b0;
    refChip = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (fanMask[i] && !found) begin
        refChip = CS_W'(i);
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    strobe = '0;
    if (rdGo && !sizeZero) strobe.pushRw = 1'b1;
    if (wrGo) begin
      if (!burstOpen) begin
        if (!sizeZero) begin
          strobe.wdBeat = 1'b1;
          if (reqSize == SIZE_W'(1)) begin
            strobe.pushRw  = 1'b1;
            strobe.isWrite = 1'b1;
            strobe.wdLast  = 1'b1;
          end else begin
            strobe.capture = 1'b1;
          end
        end
      end else begin
        strobe.wdBeat = 1'b1;
        if (remain == SIZE_W'(1)) begin
          strobe.pushRw      = 1'b1;
          strobe.isWrite     = 1'b1;
          strobe.useCaptured = 1'b1;
          strobe.wdLast      = 1'b1;
        end
      end
    end
    if (fanBusy && !queueFull) strobe.pushRefresh = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      live      <= 1'b0;
      burstOpen <= 1'b0;
      remain    <= '0;
      fanMask   <= '0;
      errProto  <= 1'b0;
      errSize   <= 1'b0;
    end else begin
      live <= 1'b1;
      if (live && conflict) errProto <= 1'b1;
      if ((rdGo || (wrGo && !burstOpen)) && sizeZero) errSize <= 1'b1;
      if (strobe.capture) begin
        burstOpen <= 1'b1;
        remain    <= reqSize - SIZE_W'(1);
      end else if (wrGo && burstOpen) begin
        if (remain == SIZE_W'(1)) burstOpen <= 1'b0;
        remain <= remain - SIZE_W'(1);
      end
      if (refGo) fanMask <= refChipMask;
      else if (strobe.pushRefresh) fanMask[refChip] <= 1'b0;
    end
  end

  assert_fanout_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (refGo && |refChipMask) |=> !reqReady);
  assert_proto_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    errProto |=> errProto);
  assert_size_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    errSize |=> errSize);

endmodule

// File: rtl/memfe_datapath.sv
module memfe_datapath
  import memfe_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 5,
  parameter int DATA_W = 16,
  parameter int CS_W   = 2,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [CS_W-1:0]   refChip,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqAutoPch,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              cmdReady,
  output logic              queueFull,
  output logic              cmdValid,
  output logic [1:0]        cmdKind,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [SIZE_W-1:0] cmdSize,
  output logic              cmdAutoPch,
  output logic [CS_W-1:0]   cmdChip,
  output logic              wdOutValid,
  output logic [DATA_W-1:0] wdOutData,
  output logic              wdOutLast
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [1:0]        qKind [DEPTH];
  logic [ADDR_W-1:0] qAddr [DEPTH];
  logic [SIZE_W-1:0] qSize [DEPTH];
  logic              qApch [DEPTH];
  logic [CS_W-1:0]   qChip [DEPTH];

  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] capAddr;
  logic [SIZE_W-1:0] capSize;
  logic              capApch;

  logic              doPush, doPop;
  cmdKind_e          newKind;
  logic [ADDR_W-1:0] newAddr;
  logic [SIZE_W-1:0] newSize;
  logic              newApch;
  logic [CS_W-1:0]   newChip;

  assign doPush    = strobe.pushRw || strobe.pushRefresh;
  assign cmdValid  = (count != '0);
  assign doPop     = cmdValid && cmdReady;
  assign queueFull = (count == CNT_W'(DEPTH));

  always_comb begin
    if (strobe.pushRefresh) begin
      newKind = KIND_REFRESH;
      newAddr = '0;
      newSize = '0;
      newApch = 1'b0;
      newChip = refChip;
    end else begin
      newKind = strobe.isWrite ? KIND_WRITE : KIND_READ;
      newAddr = strobe.useCaptured ? capAddr : reqAddr;
      newSize = strobe.useCaptured ? capSize : reqSize;
      newApch = strobe.useCaptured ? capApch : reqAutoPch;
      newChip = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) begin
      qKind[wrPtr] <= newKind;
      qAddr[wrPtr] <= newAddr;
      qSize[wrPtr] <= newSize;
      qApch[wrPtr] <= newApch;
      qChip[wrPtr] <= newChip;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      capAddr    <= '0;
      capSize    <= '0;
      capApch    <= 1'b0;
      wdOutValid <= 1'b0;
      wdOutData  <= '0;
      wdOutLast  <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      if (doPush && !doPop)      count <= count + CNT_W'(1);
      else if (doPop && !doPush) count <= count - CNT_W'(1);
      if (strobe.capture) begin
        capAddr <= reqAddr;
        capSize <= reqSize;
        capApch <= reqAutoPch;
      end
      wdOutValid <= strobe.wdBeat;
      wdOutLast  <= strobe.wdLast;
      if (strobe.wdBeat) wdOutData <= reqWdata;
    end
  end

  assign cmdKind    = qKind[rdPtr];
  assign cmdAddr    = qAddr[rdPtr];
  assign cmdSize    = qSize[rdPtr];
  assign cmdAutoPch = qApch[rdPtr];
  assign cmdChip    = qChip[rdPtr];

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    queueFull |-> !doPush);
  assert_head_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdKind) && $stable(cmdAddr)
                                 && $stable(cmdSize) && $stable(cmdChip)));
  assert_refresh_ascending_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushRefresh && $past(strobe.pushRefresh)) |-> (refChip > $past(refChip)));

endmodule

// File: rtl/memReqFrontEnd.sv
module memReqFrontEnd
  import memfe_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int MEM_DQ_W    = 8,
  parameter int RATE_MULT   = 2,
  parameter int MAX_BURST   = 16,
  parameter int NUM_CS      = 4,
  parameter int QUEUE_DEPTH = 4,
  localparam int DATA_W = MEM_DQ_W * RATE_MULT,
  localparam int SIZE_W = $clog2(MAX_BURST + 1),
  localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqRead,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqAutoPch,
  input  logic              refReq,
  input  logic [NUM_CS-1:0] refChipMask,
  output logic              reqReady,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [1:0]        cmdKind,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [SIZE_W-1:0] cmdSize,
  output logic              cmdAutoPch,
  output logic [CS_W-1:0]   cmdChip,
  output logic              wdOutValid,
  output logic [DATA_W-1:0] wdOutData,
  output logic              wdOutLast,
  output logic              errProto,
  output logic              errSize
);

  ctlStrobe_t      strobe;
  logic [CS_W-1:0] refChip;
  logic            queueFull;

  initial begin
    if (!(RATE_MULT == 2 || RATE_MULT == 4 || RATE_MULT == 8))
      $error("RATE_MULT must be 2, 4 or 8 (R5)");
    if (MAX_BURST < 1 || MAX_BURST > 1024)
      $error("MAX_BURST must lie in 1..1024 (R1)");
  end

  memfe_ctrl #(.SIZE_W(SIZE_W), .NUM_CS(NUM_CS), .CS_W(CS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqRead(reqRead), .reqWrite(reqWrite),
    .reqSize(reqSize), .refReq(refReq), .refChipMask(refChipMask),
    .queueFull(queueFull), .reqReady(reqReady), .strobe(strobe),
    .refChip(refChip), .errProto(errProto), .errSize(errSize)
  );

  memfe_datapath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W),
                   .CS_W(CS_W), .DEPTH(QUEUE_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .refChip(refChip),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqAutoPch(reqAutoPch),
    .reqWdata(reqWdata), .cmdReady(cmdReady), .queueFull(queueFull),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdAddr(cmdAddr),
    .cmdSize(cmdSize), .cmdAutoPch(cmdAutoPch), .cmdChip(cmdChip),
    .wdOutValid(wdOutValid), .wdOutData(wdOutData), .wdOutLast(wdOutLast)
  );

endmodule

// File: tb/test_memReqFrontEnd.sv
module test_memReqFrontEnd;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqRead = 0, reqWrite = 0, reqAutoPch = 0, refReq = 0, cmdReady = 0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic [4:0]  reqSize = '0;
  logic [3:0]  refChipMask = '0;
  logic        reqReady, cmdValid, cmdAutoPch, wdOutValid, wdOutLast, errProto, errSize;
  logic [1:0]  cmdKind, cmdChip;
  logic [15:0] cmdAddr, wdOutData;
  logic [4:0]  cmdSize;

  memReqFrontEnd i_memReqFrontEnd (
    .clk(clk), .rstN(rstN), .reqRead(reqRead), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .reqAutoPch(reqAutoPch), .refReq(refReq), .refChipMask(refChipMask),
    .reqReady(reqReady), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdKind(cmdKind), .cmdAddr(cmdAddr), .cmdSize(cmdSize),
    .cmdAutoPch(cmdAutoPch), .cmdChip(cmdChip), .wdOutValid(wdOutValid),
    .wdOutData(wdOutData), .wdOutLast(wdOutLast), .errProto(errProto),
    .errSize(errSize)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct packed {
    logic [1:0]  k;
    logic [15:0] a;
    logic [4:0]  s;
    logic        ap;
    logic [1:0]  c;
  } cmd_t;

  int    total = 0, bad = 0;
  cmd_t  expQ[$];
  string tagQ[$];
  logic  burstOpenM = 0;
  int    remainM = 0;
  cmd_t  capM;
  logic  expWdValid = 0, expWdLast = 0;
  logic [15:0] expWdData = '0;
  logic  expErrProto = 0, expErrSize = 0;
  logic  gRdy, crdyG = 1'b1;
  int    popCount = 0;

  task automatic checkEq(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic cmd_t mk(logic [1:0] k, logic [15:0] a, logic [4:0] s, logic ap, logic [1:0] c);
    cmd_t r;
    r.k = k; r.a = a; r.s = s; r.ap = ap; r.c = c;
    return r;
  endfunction

  task automatic pushExp(cmd_t c, string tag);
    expQ.push_back(c);
    tagQ.push_back(tag);
  endtask

  task automatic step(logic rd, logic wr, logic [15:0] a, logic [4:0] s,
                      logic [15:0] d, logic ap, logic rf, logic [3:0] m);
    cmd_t got;
    @(negedge clk);
    // R5: beat forwarded from the previous edge
    checkEq("R5", "wdOutValid", wdOutValid, expWdValid);
    if (expWdValid) begin
      checkEq("R5", "wdOutData", wdOutData, expWdData);
      checkEq("R5", "wdOutLast", wdOutLast, expWdLast);
    end
    reqRead = rd; reqWrite = wr; reqAddr = a; reqSize = s; reqWdata = d;
    reqAutoPch = ap; refReq = rf; refChipMask = m; cmdReady = crdyG;
    #5;
    gRdy = reqReady;
    if (cmdValid && cmdReady) begin
      got = mk(cmdKind, cmdAddr, cmdSize, cmdAutoPch, cmdChip);
      popCount++;
      if (expQ.size() == 0) checkEq("R11", "unexpected command", got, 0);
      else checkEq(tagQ.pop_front(), "dequeued command", got, expQ.pop_front());
    end
    expWdValid = 0; expWdLast = 0;
    if ((rd && wr) || (rd && burstOpenM)) expErrProto = 1;
    if (gRdy) begin
      if (rd && !wr && !burstOpenM) begin
        if (s == 0) expErrSize = 1;
        else pushExp(mk(2'd0, a, s, ap, 2'd0), "R1/R6 read");
      end
      if (wr && !rd) begin
        if (!burstOpenM) begin
          if (s == 0) expErrSize = 1;
          else begin
            expWdValid = 1; expWdData = d;
            if (s == 1) begin
              expWdLast = 1;
              pushExp(mk(2'd1, a, s, ap, 2'd0), "R2/R6 write");
            end else begin
              burstOpenM = 1; remainM = s - 1; capM = mk(2'd1, a, s, ap, 2'd0);
            end
          end
        end else begin
          expWdValid = 1; expWdData = d;
          if (remainM == 1) begin
            expWdLast = 1; burstOpenM = 0;
            pushExp(capM, "R2/R6 write");
          end
          remainM--;
        end
      end
      if (rf && !rd && !wr && !burstOpenM)
        for (int i = 0; i < 4; i++)
          if (m[i]) pushExp(mk(2'd2, '0, '0, 1'b0, 2'(i)), "R7 refresh");
    end
  endtask

  task automatic idle();
    step(0, 0, 16'h0, 5'd0, 16'h0, 0, 0, 4'h0);
  endtask

  task automatic doRead(logic [15:0] a, logic [4:0] s, logic ap);
    for (int t = 0; t < 50; t++) begin
      step(1, 0, a, s, 16'h0, ap, 0, 4'h0);
      if (gRdy) break;
    end
  endtask

  task automatic doWrite(logic [15:0] a, logic [4:0] s, logic ap, logic gaps);
    for (int b = 0; b < s; b++) begin
      logic [4:0] sz;
      sz = (b == 0) ? s : 5'($urandom % 32);  // R2: later sizes are noise
      if (gaps && ($urandom % 3 == 0)) idle();
      for (int t = 0; t < 50; t++) begin
        step(0, 1, a, sz, 16'($urandom), ap, 0, 4'h0);
        if (gRdy) break;
      end
    end
  endtask

  task automatic doRefresh(logic [3:0] m);
    for (int t = 0; t < 50; t++) begin
      step(0, 0, 16'h0, 5'd0, 16'h0, 0, 1, m);
      if (gRdy) break;
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL R11 watchdog expired: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // R4: requests during reset are ignored
    reqRead = 1; reqSize = 5'd2; cmdReady = 1;
    repeat (3) @(negedge clk);
    checkEq("R4", "reqReady in reset", reqReady, 0);
    checkEq("R4", "cmdValid in reset", cmdValid, 0);
    checkEq("R4", "errProto in reset", errProto, 0);
    checkEq("R4", "errSize in reset", errSize, 0);
    rstN = 1;
    #5;
    checkEq("R4", "reqReady first cycle after reset", reqReady, 0);
    reqRead = 0;
    idle();
    checkEq("R4", "queue empty after reset", cmdValid, 0);

    // R1/R6: single read with autoprecharge
    crdyG = 1;
    doRead(16'h1234, 5'd16, 1);
    // R2: write burst of 3, later sizes ignored
    doWrite(16'hbeef, 5'd3, 1, 0);
    // R5: one-beat write
    doWrite(16'h0042, 5'd1, 0, 0);
    repeat (4) idle();
    checkEq("R1", "read and writes dequeued", popCount, 3);

    // R7/R8: mask 0101 fans out to chips 0 then 2, ready drops
    doRefresh(4'b0101);
    idle();
    checkEq("R8", "reqReady during fan-out", gRdy, 0);
    repeat (4) idle();
    // R10: zero mask queues nothing, ready stays high
    doRefresh(4'b0000);
    idle();
    checkEq("R10", "reqReady after empty refresh", gRdy, 1);
    checkEq("R10", "no command after empty mask", cmdValid, 0);

    // R9: zero size read and write dropped
    step(1, 0, 16'h7, 5'd0, 16'h0, 0, 0, 4'h0);
    step(0, 1, 16'h8, 5'd0, 16'hdead, 0, 0, 4'h0);
    idle();
    checkEq("R9", "errSize", errSize, 1);
    checkEq("R9", "no command after zero size", cmdValid, 0);

    // R8: fill the queue while downstream stalls
    crdyG = 0;
    begin
      int acc = 0;
      for (int t = 0; t < 8; t++) begin
        step(1, 0, 16'(t), 5'd1, 16'h0, 0, 0, 4'h0);
        if (gRdy) acc++;
      end
      checkEq("R8", "reads taken into stalled queue", acc, DEPTH);
      checkEq("R8", "reqReady with full queue", gRdy, 0);
    end
    crdyG = 1;
    repeat (6) idle();

    // R3: overlapping read and write
    checkEq("R3", "errProto before overlap", errProto, 0);
    step(1, 1, 16'h9, 5'd2, 16'h0, 0, 0, 4'h0);
    idle();
    checkEq("R3", "errProto after overlap", errProto, 1);
    checkEq("R3", "nothing queued after overlap", cmdValid, 0);
    // R3: read while a write burst is open is dropped
    step(0, 1, 16'h55, 5'd2, 16'h1111, 0, 0, 4'h0);
    step(1, 0, 16'h66, 5'd1, 16'h0, 0, 0, 4'h0);
    step(0, 1, 16'h55, 5'd9, 16'h2222, 0, 0, 4'h0);
    repeat (3) idle();

    // random mix
    for (int n = 0; n < 400; n++) begin
      int pick;
      crdyG = ($urandom % 4) != 0;
      pick = $urandom % 10;
      if (pick < 4)      doRead(16'($urandom), 5'($urandom % 16 + 1), 1'($urandom));
      else if (pick < 8) doWrite(16'($urandom), 5'($urandom % 4 + 1), 1'($urandom), 1);
      else if (pick < 9) doRefresh(4'($urandom));
      else               idle();
    end
    crdyG = 1;
    repeat (30) idle();
    checkEq("R11", "expected commands left", expQ.size(), 0);
    checkEq("R3", "errProto final", errProto, expErrProto);
    checkEq("R9", "errSize final", errSize, expErrSize);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule